// File: doc/BRIEF.md
# Multi-Channel Coefficient Staging Bank

This block keeps the coefficient words for a set of waveform-generator channels (four by default) and decides when each generator sees a new set. Every channel holds fifteen 16-bit words in two copies. The staged copy receives bus writes. The live copy drives the generator. Words 0 to 8 describe the amplitude polynomial and words 9 to 14 describe phase, frequency, chirp and a clock-division shift. A write selects a channel and a word index, and it only ever changes the staged copy.

Two commit strobes move staged words into the live copy. The amplitude strobe moves words 0 to 8 and the phase strobe moves words 9 to 14. Each strobe carries its own channel mask, so several generators pick up new values on the same clock edge. Every committed channel gets a one-cycle load pulse for that half. A full update normally sends the amplitude commit first and the phase commit one coarse cycle later. A 4-bit clear register, written as a whole, switches each channel's output off. A read port returns staged words so software can check what has been loaded.

Top module: `coef_stage_bank`

## Requirements
- R1: After reset, all staged and live words are zero and both load pulse vectors are low. The clear register holds all ones, so `ch_enable_o` is all zero.
- R2: A write with `wr_en` high, channel c and index 0..14 updates only staged word (c, index) at the next clock edge. Index 15 stores nothing. `rd_data` returns staged word (`rd_chan`, `rd_idx`) combinationally, and returns zero for index 15.
- R3: For word 14, write bits 15:6 are discarded and read back as zero. Bits 5:0 are kept.
- R4: Staged words have no effect on any coefficient output until a matching commit moves them.
- R5: When `trig_b_valid` is high, staged words 0..8 are copied to the live copy for each channel whose mask bit is set, and the phase words are left alone. In the next cycle `load_b_o` equals that mask for exactly one cycle.
- R6: When `trig_c_valid` is high, staged words 9..14 are copied in the same way and the amplitude words are left alone. `load_c_o` pulses with that mask for one cycle.
- R7: Amplitude fields per channel are assembled low word first: offset = word 0, first-order = {w2,w1}, second-order = {w5,w4,w3}, third-order = {w8,w7,w6}.
- R8: Phase fields per channel: 18-bit offset = {w9, w14[5:4]}, tuning word = {w11,w10}, chirp = {w13,w12}, shift = w14[3:0].
- R9: A commit copies the staged value held before that cycle's write. A word written in the same cycle as a commit stays staged and goes live only on a later commit.
- R10: Mask bit i selects channel i, and only channel i. Amplitude and phase commits in the same cycle with different masks act independently.
- R11: A clear write replaces the whole 4-bit clear register at the next edge. `ch_enable_o[i]` is the inverse of clear bit i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Staged word write strobe |
| wr_chan | input | 2 | Channel of the write |
| wr_idx | input | 4 | Word index of the write (0..14) |
| wr_data | input | 16 | Write data |
| trig_b_valid | input | 1 | Amplitude commit strobe |
| trig_b_mask | input | 4 | Channels for amplitude commit |
| trig_c_valid | input | 1 | Phase commit strobe |
| trig_c_mask | input | 4 | Channels for phase commit |
| clr_wr | input | 1 | Clear register write strobe |
| clr_data | input | 4 | New clear mask, 1 disables a channel |
| rd_chan | input | 2 | Readback channel |
| rd_idx | input | 4 | Readback word index |
| rd_data | output | 16 | Staged word readback |
| load_b_o | output | 4 | One-cycle amplitude load pulse per channel |
| load_c_o | output | 4 | One-cycle phase load pulse per channel |
| ch_enable_o | output | 4 | Per-channel output enable |
| amp_offset_o | output | 64 | Live offset, 16 bits per channel |
| amp_lin_o | output | 128 | Live first-order term, 32 bits per channel |
| amp_quad_o | output | 192 | Live second-order term, 48 bits per channel |
| amp_cub_o | output | 192 | Live third-order term, 48 bits per channel |
| ph_off_o | output | 72 | Live phase offset, 18 bits per channel |
| ph_ftw_o | output | 128 | Live tuning word, 32 bits per channel |
| ph_chirp_o | output | 128 | Live chirp, 32 bits per channel |
| ph_shift_o | output | 16 | Live shift, 4 bits per channel |

## Verification
The bench writes a value and commits the same word in the same cycle. A bank that commits the incoming data instead of the value held beforehand fails this test, because the new offset shows up at once. It sends simultaneous amplitude and phase commits with disjoint masks, which catches a design that mixes up the two masks or copies the wrong word range. The reserved bits of word 14 are written as ones and checked for both readback and the assembled 18-bit phase offset, which catches a swapped or unmasked low-bit field. Index 15 writes and masked-out channels are checked for leakage into neighbouring words and channels.

// File: rtl/coef_bank_pkg.sv
package coef_bank_pkg;
    localparam int WORD_W      = 16;
    localparam int AMP_WORDS   = 9;
    localparam int PH_WORDS    = 6;
    localparam int TOTAL_WORDS = AMP_WORDS + PH_WORDS;
    localparam int IDX_W       = 4;
    localparam int SHIFT_WORD  = TOTAL_WORDS - 1;
    localparam int SHIFT_W     = 4;
    localparam int PH_LSB_W    = 2;
    localparam int KEEP_W      = SHIFT_W + PH_LSB_W;
    localparam int PH_OFF_W    = WORD_W + PH_LSB_W;

    typedef logic [WORD_W-1:0] word_t;

    typedef struct packed {
        word_t [TOTAL_WORDS-1:0] pend;
        word_t [TOTAL_WORDS-1:0] act;
        logic                    ld_b;
        logic                    ld_c;
    } chan_state_t;
endpackage

// File: rtl/coef_wr_decode.sv
module coef_wr_decode
    import coef_bank_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int CH_W   = 2
) (
    input  logic                                  wr_en,
    input  logic [CH_W-1:0]                       wr_chan,
    input  logic [IDX_W-1:0]                      wr_idx,
    input  logic                                  trig_b_valid,
    input  logic [NUM_CH-1:0]                     trig_b_mask,
    input  logic                                  trig_c_valid,
    input  logic [NUM_CH-1:0]                     trig_c_mask,
    output logic [NUM_CH-1:0][TOTAL_WORDS-1:0]    word_we,
    output logic [NUM_CH-1:0]                     commit_b,
    output logic [NUM_CH-1:0]                     commit_c
);
    always_comb begin
        for (int c = 0; c < NUM_CH; c++) begin
            for (int w = 0; w < TOTAL_WORDS; w++) begin
                word_we[c][w] = wr_en && (wr_chan == CH_W'(c)) && (wr_idx == IDX_W'(w));
            end
        end
        commit_b = trig_b_valid ? trig_b_mask : '0;
        commit_c = trig_c_valid ? trig_c_mask : '0;
    end
endmodule

// File: rtl/coef_channel.sv
module coef_channel
    import coef_bank_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [TOTAL_WORDS-1:0]  word_we,
    input  word_t                   wr_data,
    input  logic                    commit_b,
    input  logic                    commit_c,
    output word_t [TOTAL_WORDS-1:0] pend_o,
    output word_t [TOTAL_WORDS-1:0] act_o,
    output logic                    ld_b_o,
    output logic                    ld_c_o
);
    localparam word_t KEEP_MASK = word_t'((1 << KEEP_W) - 1);

    chan_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.ld_b = commit_b;
        st_d.ld_c = commit_c;
        for (int w = 0; w < TOTAL_WORDS; w++) begin
            if (word_we[w]) begin
                st_d.pend[w] = (w == SHIFT_WORD) ? (wr_data & KEEP_MASK) : wr_data;
            end
        end
        for (int w = 0; w < TOTAL_WORDS; w++) begin
            if (w < AMP_WORDS) begin
                if (commit_b) st_d.act[w] = st_q.pend[w];
            end else begin
                if (commit_c) st_d.act[w] = st_q.pend[w];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend_o = st_q.pend;
    assign act_o  = st_q.act;
    assign ld_b_o = st_q.ld_b;
    assign ld_c_o = st_q.ld_c;
endmodule

// File: rtl/coef_clear_reg.sv
module coef_clear_reg #(
    parameter int NUM_CH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_wr,
    input  logic [NUM_CH-1:0] clr_data,
    output logic [NUM_CH-1:0] ch_enable_o
);
    typedef struct packed {
        logic [NUM_CH-1:0] clr;
    } clr_state_t;

    clr_state_t cs_d, cs_q;

    always_comb begin
        cs_d = cs_q;
        if (clr_wr) cs_d.clr = clr_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cs_q.clr <= '1;
        else        cs_q     <= cs_d;
    end

    assign ch_enable_o = ~cs_q.clr;
endmodule

// File: rtl/coef_stage_bank.sv
module coef_stage_bank
    import coef_bank_pkg::*;
#(
    parameter int NUM_CH = 4,
    localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [CH_W-1:0]          wr_chan,
    input  logic [IDX_W-1:0]         wr_idx,
    input  logic [WORD_W-1:0]        wr_data,
    input  logic                     trig_b_valid,
    input  logic [NUM_CH-1:0]        trig_b_mask,
    input  logic                     trig_c_valid,
    input  logic [NUM_CH-1:0]        trig_c_mask,
    input  logic                     clr_wr,
    input  logic [NUM_CH-1:0]        clr_data,
    input  logic [CH_W-1:0]          rd_chan,
    input  logic [IDX_W-1:0]         rd_idx,
    output logic [WORD_W-1:0]        rd_data,
    output logic [NUM_CH-1:0]        load_b_o,
    output logic [NUM_CH-1:0]        load_c_o,
    output logic [NUM_CH-1:0]        ch_enable_o,
    output logic [NUM_CH*16-1:0]     amp_offset_o,
    output logic [NUM_CH*32-1:0]     amp_lin_o,
    output logic [NUM_CH*48-1:0]     amp_quad_o,
    output logic [NUM_CH*48-1:0]     amp_cub_o,
    output logic [NUM_CH*PH_OFF_W-1:0] ph_off_o,
    output logic [NUM_CH*32-1:0]     ph_ftw_o,
    output logic [NUM_CH*32-1:0]     ph_chirp_o,
    output logic [NUM_CH*SHIFT_W-1:0] ph_shift_o
);
    logic [NUM_CH-1:0][TOTAL_WORDS-1:0] word_we;
    logic [NUM_CH-1:0]                  commit_b, commit_c;
    word_t [NUM_CH-1:0][TOTAL_WORDS-1:0] pend_all, act_all;

    coef_wr_decode #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_dec (
        .wr_en        (wr_en),
        .wr_chan      (wr_chan),
        .wr_idx       (wr_idx),
        .trig_b_valid (trig_b_valid),
        .trig_b_mask  (trig_b_mask),
        .trig_c_valid (trig_c_valid),
        .trig_c_mask  (trig_c_mask),
        .word_we      (word_we),
        .commit_b     (commit_b),
        .commit_c     (commit_c)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        coef_channel u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .word_we  (word_we[c]),
            .wr_data  (wr_data),
            .commit_b (commit_b[c]),
            .commit_c (commit_c[c]),
            .pend_o   (pend_all[c]),
            .act_o    (act_all[c]),
            .ld_b_o   (load_b_o[c]),
            .ld_c_o   (load_c_o[c])
        );

        assign amp_offset_o[c*16 +: 16] = act_all[c][0];
        assign amp_lin_o[c*32 +: 32]    = {act_all[c][2], act_all[c][1]};
        assign amp_quad_o[c*48 +: 48]   = {act_all[c][5], act_all[c][4], act_all[c][3]};
        assign amp_cub_o[c*48 +: 48]    = {act_all[c][8], act_all[c][7], act_all[c][6]};
        assign ph_off_o[c*PH_OFF_W +: PH_OFF_W] =
            {act_all[c][AMP_WORDS], act_all[c][SHIFT_WORD][SHIFT_W +: PH_LSB_W]};
        assign ph_ftw_o[c*32 +: 32]     = {act_all[c][11], act_all[c][10]};
        assign ph_chirp_o[c*32 +: 32]   = {act_all[c][13], act_all[c][12]};
        assign ph_shift_o[c*SHIFT_W +: SHIFT_W] = act_all[c][SHIFT_WORD][SHIFT_W-1:0];
    end

    coef_clear_reg #(.NUM_CH(NUM_CH)) u_clr (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr_wr      (clr_wr),
        .clr_data    (clr_data),
        .ch_enable_o (ch_enable_o)
    );

    always_comb begin
        rd_data = '0;
        for (int w = 0; w < TOTAL_WORDS; w++) begin
            if (rd_idx == IDX_W'(w)) rd_data = pend_all[rd_chan][w];
        end
    end
endmodule

// File: rtl/coef_stage_bank_chk.sv
module coef_stage_bank_chk
    import coef_bank_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int CH_W   = 2
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        trig_b_valid,
    input logic [NUM_CH-1:0]           trig_b_mask,
    input logic                        trig_c_valid,
    input logic [NUM_CH-1:0]           trig_c_mask,
    input logic                        clr_wr,
    input logic [NUM_CH-1:0]           clr_data,
    input logic [IDX_W-1:0]            rd_idx,
    input logic [WORD_W-1:0]           rd_data,
    input logic [NUM_CH-1:0]           load_b_o,
    input logic [NUM_CH-1:0]           load_c_o,
    input logic [NUM_CH-1:0]           ch_enable_o,
    input logic [NUM_CH*16-1:0]        amp_offset_o,
    input logic [NUM_CH*32-1:0]        amp_lin_o,
    input logic [NUM_CH*PH_OFF_W-1:0]  ph_off_o,
    input logic [NUM_CH*32-1:0]        ph_ftw_o
);
    // R5: amplitude load pulse mirrors the commit mask one cycle later
    p_load_b_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
        trig_b_valid |=> (load_b_o == $past(trig_b_mask)));
    p_load_b_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !trig_b_valid |=> (load_b_o == '0));
    // R6: phase load pulse mirrors its own mask
    p_load_c_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
        trig_c_valid |=> (load_c_o == $past(trig_c_mask)));
    // R4: live amplitude words hold without an amplitude commit
    p_amp_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !trig_b_valid |=> ($stable(amp_offset_o) && $stable(amp_lin_o)));
    // R4: live phase words hold without a phase commit
    p_ph_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !trig_c_valid |=> ($stable(ph_off_o) && $stable(ph_ftw_o)));
    // R11: enable follows the inverse of the written clear mask
    p_clr_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
        clr_wr |=> (ch_enable_o == ~$past(clr_data)));
    p_clr_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_wr |=> $stable(ch_enable_o));
    // R3: reserved bits of the shift word always read as zero
    p_rsv_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_idx == IDX_W'(SHIFT_WORD)) |-> (rd_data[WORD_W-1:KEEP_W] == '0));
endmodule

bind coef_stage_bank coef_stage_bank_chk #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .trig_b_valid (trig_b_valid),
    .trig_b_mask  (trig_b_mask),
    .trig_c_valid (trig_c_valid),
    .trig_c_mask  (trig_c_mask),
    .clr_wr       (clr_wr),
    .clr_data     (clr_data),
    .rd_idx       (rd_idx),
    .rd_data      (rd_data),
    .load_b_o     (load_b_o),
    .load_c_o     (load_c_o),
    .ch_enable_o  (ch_enable_o),
    .amp_offset_o (amp_offset_o),
    .amp_lin_o    (amp_lin_o),
    .ph_off_o     (ph_off_o),
    .ph_ftw_o     (ph_ftw_o)
);

// File: tb/tb_coef_stage_bank.sv
module tb_coef_stage_bank;
    localparam int NCH = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 1'b0;
    logic [1:0]   wr_chan = '0;
    logic [3:0]   wr_idx = '0;
    logic [15:0]  wr_data = '0;
    logic         trig_b_valid = 1'b0;
    logic [3:0]   trig_b_mask = '0;
    logic         trig_c_valid = 1'b0;
    logic [3:0]   trig_c_mask = '0;
    logic         clr_wr = 1'b0;
    logic [3:0]   clr_data = '0;
    logic [1:0]   rd_chan = '0;
    logic [3:0]   rd_idx = '0;
    logic [15:0]  rd_data;
    logic [3:0]   load_b_o, load_c_o, ch_enable_o;
    logic [NCH*16-1:0] amp_offset_o;
    logic [NCH*32-1:0] amp_lin_o;
    logic [NCH*48-1:0] amp_quad_o;
    logic [NCH*48-1:0] amp_cub_o;
    logic [NCH*18-1:0] ph_off_o;
    logic [NCH*32-1:0] ph_ftw_o;
    logic [NCH*32-1:0] ph_chirp_o;
    logic [NCH*4-1:0]  ph_shift_o;

    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk;

    coef_stage_bank #(.NUM_CH(NCH)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_chan(wr_chan), .wr_idx(wr_idx),
        .wr_data(wr_data), .trig_b_valid(trig_b_valid), .trig_b_mask(trig_b_mask),
        .trig_c_valid(trig_c_valid), .trig_c_mask(trig_c_mask), .clr_wr(clr_wr),
        .clr_data(clr_data), .rd_chan(rd_chan), .rd_idx(rd_idx), .rd_data(rd_data),
        .load_b_o(load_b_o), .load_c_o(load_c_o), .ch_enable_o(ch_enable_o),
        .amp_offset_o(amp_offset_o), .amp_lin_o(amp_lin_o), .amp_quad_o(amp_quad_o),
        .amp_cub_o(amp_cub_o), .ph_off_o(ph_off_o), .ph_ftw_o(ph_ftw_o),
        .ph_chirp_o(ph_chirp_o), .ph_shift_o(ph_shift_o)
    );

    // {chan[1:0], idx[3:0], data[15:0], expected readback[15:0]}
    localparam logic [37:0] VEC [12] = '{
        {2'd0, 4'd0,  16'h1111, 16'h1111},
        {2'd0, 4'd14, 16'hFFC5, 16'h0005},
        {2'd1, 4'd14, 16'hFFFF, 16'h003F},
        {2'd2, 4'd15, 16'hBEEF, 16'h0000},
        {2'd3, 4'd9,  16'h1234, 16'h1234},
        {2'd2, 4'd8,  16'h8888, 16'h8888},
        {2'd1, 4'd5,  16'h0505, 16'h0505},
        {2'd3, 4'd14, 16'h0040, 16'h0000},
        {2'd0, 4'd13, 16'hDDDD, 16'hDDDD},
        {2'd2, 4'd1,  16'h00F1, 16'h00F1},
        {2'd1, 4'd0,  16'h7E00, 16'h7E00},
        {2'd3, 4'd3,  16'h3003, 16'h3003}
    };

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [1:0] ch, input logic [3:0] idx, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_chan = ch; wr_idx = idx; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_trig(input logic bv, input logic [3:0] bm, input logic cv, input logic [3:0] cm);
        @(negedge clk);
        trig_b_valid = bv; trig_b_mask = bm; trig_c_valid = cv; trig_c_mask = cm;
        @(negedge clk);
        trig_b_valid = 1'b0; trig_c_valid = 1'b0;
    endtask

    task automatic readback(input logic [1:0] ch, input logic [3:0] idx, output logic [15:0] v);
        rd_chan = ch; rd_idx = idx;
        #1;
        v = rd_data;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [15:0] rv;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 enable", ch_enable_o, 4'h0);
        check("R1 loads", {load_b_o, load_c_o}, 8'h00);
        check("R1 amp offset", amp_offset_o, 64'h0);
        check("R1 phase ftw", ph_ftw_o[63:0], 64'h0);
        readback(2'd1, 4'd7, rv);
        check("R1 staged word", rv, 16'h0);
        rst_n = 1'b1;

        // R2 / R3: table-driven writes with readback
        for (int i = 0; i < 12; i++) begin
            do_write(VEC[i][37:36], VEC[i][35:32], VEC[i][31:16]);
            readback(VEC[i][37:36], VEC[i][35:32], rv);
            check("R2/R3 readback", rv, VEC[i][15:0]);
        end
        for (int i = 0; i < 12; i++) begin
            readback(VEC[i][37:36], VEC[i][35:32], rv);
            check("R2 isolation reread", rv, VEC[i][15:0]);
        end
        readback(2'd2, 4'd0, rv);
        check("R2 index 15 no leak", rv, 16'h0);

        // R4: nothing live yet
        check("R4 amp untouched", amp_offset_o, 64'h0);
        check("R4 phase untouched", ph_off_o, 72'h0);

        // Fill channel 1
        do_write(2'd1, 4'd0, 16'h0A01);
        do_write(2'd1, 4'd1, 16'h1111);
        do_write(2'd1, 4'd2, 16'h2222);
        do_write(2'd1, 4'd3, 16'h3333);
        do_write(2'd1, 4'd4, 16'h4444);
        do_write(2'd1, 4'd5, 16'h5555);
        do_write(2'd1, 4'd6, 16'h6666);
        do_write(2'd1, 4'd7, 16'h7777);
        do_write(2'd1, 4'd8, 16'h8888);
        do_write(2'd1, 4'd9, 16'hABCD);
        do_write(2'd1, 4'd10, 16'hAAAA);
        do_write(2'd1, 4'd11, 16'hBBBB);
        do_write(2'd1, 4'd12, 16'hCCCC);
        do_write(2'd1, 4'd13, 16'hDDDD);
        do_write(2'd1, 4'd14, 16'hFFF7);

        // R5: amplitude commit for channel 1
        do_trig(1'b1, 4'b0010, 1'b0, 4'b0000);
        check("R5 load_b pulse", load_b_o, 4'b0010);
        check("R5 no load_c", load_c_o, 4'b0000);
        check("R7 offset ch1", amp_offset_o[16 +: 16], 16'h0A01);
        check("R7 first-order ch1", amp_lin_o[32 +: 32], 32'h22221111);
        check("R7 second-order ch1", amp_quad_o[48 +: 48], 48'h555544443333);
        check("R7 third-order ch1", amp_cub_o[48 +: 48], 48'h888877776666);
        check("R5 phase untouched ch1", ph_ftw_o[32 +: 32], 32'h0);
        check("R10 ch0 masked out", amp_offset_o[0 +: 16], 16'h0);
        @(negedge clk);
        check("R5 load_b one cycle", load_b_o, 4'b0000);

        // R6 / R8: phase commit for channel 1
        do_trig(1'b0, 4'b0000, 1'b1, 4'b0010);
        check("R6 load_c pulse", load_c_o, 4'b0010);
        check("R6 no load_b", load_b_o, 4'b0000);
        check("R8 phase offset ch1", ph_off_o[18 +: 18], {16'hABCD, 2'b11});
        check("R8 ftw ch1", ph_ftw_o[32 +: 32], 32'hBBBBAAAA);
        check("R8 chirp ch1", ph_chirp_o[32 +: 32], 32'hDDDDCCCC);
        check("R8 shift ch1", ph_shift_o[4 +: 4], 4'h7);
        check("R6 amp unchanged ch1", amp_offset_o[16 +: 16], 16'h0A01);
        @(negedge clk);
        check("R6 load_c one cycle", load_c_o, 4'b0000);

        // R9: write and commit in the same cycle
        @(negedge clk);
        wr_en = 1'b1; wr_chan = 2'd0; wr_idx = 4'd0; wr_data = 16'h5555;
        trig_b_valid = 1'b1; trig_b_mask = 4'b0001;
        @(negedge clk);
        wr_en = 1'b0; trig_b_valid = 1'b0;
        check("R9 old value committed", amp_offset_o[0 +: 16], 16'h1111);
        readback(2'd0, 4'd0, rv);
        check("R9 new value staged", rv, 16'h5555);
        do_trig(1'b1, 4'b0001, 1'b0, 4'b0000);
        check("R9 later commit", amp_offset_o[0 +: 16], 16'h5555);

        // R10: simultaneous independent masks
        do_write(2'd2, 4'd11, 16'h4242);
        do_trig(1'b1, 4'b1000, 1'b1, 4'b0100);
        check("R10 load_b mask", load_b_o, 4'b1000);
        check("R10 load_c mask", load_c_o, 4'b0100);
        check("R10 ch3 amp live", amp_quad_o[144 +: 48], 48'h000000003003);
        check("R10 ch3 phase held", ph_off_o[54 +: 18], 18'h0);
        check("R10 ch2 amp held", amp_cub_o[96 +: 48], 48'h0);
        check("R10 ch2 phase live", ph_ftw_o[64 +: 32], 32'h42420000);
        check("R10 ch0 phase held", ph_chirp_o[0 +: 32], 32'h0);

        // R11: clear register
        @(negedge clk);
        clr_wr = 1'b1; clr_data = 4'b0101;
        @(negedge clk);
        clr_wr = 1'b0; clr_data = 4'b1111;
        check("R11 enable after clear", ch_enable_o, 4'b1010);
        @(negedge clk);
        check("R11 hold without write", ch_enable_o, 4'b1010);
        clr_wr = 1'b1; clr_data = 4'b0000;
        @(negedge clk);
        clr_wr = 1'b0;
        check("R11 all enabled", ch_enable_o, 4'b1111);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule